// File: doc/BRIEF.md
# Interrupt Target Routing Bank

This block holds the CPU routing choice for every shared interrupt of an interrupt distributor serving up to eight CPUs. Software sees the routing as a bank of 32-bit words, each covering four consecutive interrupt IDs with one 8-bit CPU mask per interrupt. Inside, each shared interrupt keeps only a CPU index. A write is therefore reduced to a single destination: the lowest set bit of each mask byte wins, and an empty byte falls back to CPU 0.

The first 32 interrupt IDs are private to each CPU and cannot be rerouted. Their words read back the one-hot bit of the CPU making the access, and writes to them have no effect. Words past the configured interrupt count read as zero. Alongside the register view, the block drives a per-interrupt, per-CPU routing bitmap that the pending and forwarding logic downstream consumes. It also pulses a strobe whenever the routing changes, so that logic can re-evaluate.

Top module: `tgt_bank`

## Requirements
- R1: Word index w covers interrupt IDs 4w to 4w+3. Interrupt 4w+j sits in bits [8j+7:8j] of the word.
- R2: A write to a shared word stores, for each byte, the position of its lowest set bit as that interrupt's CPU index. A later read returns, in that byte, a value with only the bit at the stored index set.
- R3: A written byte that is zero routes its interrupt to CPU 0. Byte bits at positions of NUM_CPU or above are disregarded.
- R4: Words with index below 8 (IDs 0..31) read as the byte (1 << acc_cpu) in all four byte lanes. Writes to them change no stored routing and raise no strobe.
- R5: For shared interrupt s = ID-32, route_map bits [s*NUM_CPU +: NUM_CPU] always have exactly one bit set, at position c equal to the stored CPU index.
- R6: After reset, every shared interrupt is routed to CPU 0.
- R7: A write to an in-range shared word raises upd for exactly one cycle, in the cycle after the write. route_map shows the new routing in that same cycle. route_map does not change in any other cycle.
- R8: Word indices at or beyond NUM_IRQ/4 read as zero. Writes to them have no effect and raise no strobe.
- R9: Read data and rd_valid appear in the cycle after rd_en is sampled, and rd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for word_idx |
| rd_en | input | 1 | Read request for word_idx |
| word_idx | input | WIDX_W (5) | Target word index (interrupt ID / 4) |
| wr_data | input | 32 | Four 8-bit CPU masks |
| acc_cpu | input | CPU_W (3) | Index of the CPU performing the access |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data is valid this cycle |
| upd | output | 1 | One-cycle routing-changed strobe |
| route_map | output | (NUM_IRQ-32)*NUM_CPU (256) | One-hot CPU mask per shared interrupt |

## Verification
The bench writes bytes with several bits set and bytes that are zero. A design that stored the highest bit, or kept the whole mask, would read back multi-bit bytes or light several route_map bits, and one that mishandled zero would leave the interrupt unrouted. It writes all-ones into private words and then reads them as several different CPUs. A bank that let those writes through, or returned a fixed CPU, would show changed bytes or a raised strobe. Random word indices also land beyond the configured range, where a decoder that wrapped the index would corrupt low shared entries or return their data instead of zero.

// File: rtl/tgt_bank_pkg.sv
package tgt_bank_pkg;

  typedef enum logic [1:0] {
    WK_PRIV   = 2'd0,
    WK_SHARED = 2'd1,
    WK_NONE   = 2'd2
  } word_kind_e;

  // Position of the lowest set bit, zero when no bit is set.
  function automatic logic [2:0] lowest_set(input logic [7:0] b);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (b[i]) r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/tgt_slot.sv
module tgt_slot
  import tgt_bank_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [7:0]         wbyte,
  output logic [CPU_W-1:0]   idx,
  output logic [NUM_CPU-1:0] map
);
  localparam logic [7:0] CPU_MASK = (NUM_CPU >= 8) ? 8'hFF : 8'((1 << NUM_CPU) - 1);

  logic [CPU_W-1:0] nxt_idx;

  always_comb begin
    nxt_idx = CPU_W'(lowest_set(wbyte & CPU_MASK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      map <= NUM_CPU'(1);
    end else if (we) begin
      idx <= nxt_idx;
      map <= NUM_CPU'(1) << nxt_idx;
    end
  end
endmodule

// File: rtl/tgt_rd.sv
module tgt_rd
  import tgt_bank_pkg::*;
#(
  parameter int CPU_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  word_kind_e       kind,
  input  logic [CPU_W-1:0] acc_cpu,
  input  logic [4*CPU_W-1:0] lane_idx,
  output logic [31:0]      rd_data,
  output logic             rd_valid
);
  logic [31:0] word_c;

  always_comb begin
    word_c = '0;
    for (int j = 0; j < 4; j++) begin
      unique case (kind)
        WK_PRIV:   word_c[8*j +: 8] = 8'(8'd1 << acc_cpu);
        WK_SHARED: word_c[8*j +: 8] = 8'(8'd1 << lane_idx[CPU_W*j +: CPU_W]);
        default:   word_c[8*j +: 8] = 8'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_c;
    end
  end
endmodule

// File: rtl/tgt_bank.sv
module tgt_bank
  import tgt_bank_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  localparam int PRIV   = 32,
  localparam int NSH    = NUM_IRQ - PRIV,
  localparam int NWORD  = NUM_IRQ / 4,
  localparam int WIDX_W = $clog2(NWORD) + 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [WIDX_W-1:0]      word_idx,
  input  logic [31:0]            wr_data,
  input  logic [CPU_W-1:0]       acc_cpu,
  output logic [31:0]            rd_data,
  output logic                   rd_valid,
  output logic                   upd,
  output logic [NSH*NUM_CPU-1:0] route_map
);
  localparam int SL_W = (NSH > 1) ? $clog2(NSH) : 1;
  localparam int BA_W = WIDX_W + 2;

  word_kind_e        kind;
  logic [BA_W-1:0]   base_irq;
  logic [BA_W-1:0]   base_sh;
  logic [CPU_W-1:0]  cur_idx [NSH];
  logic [4*CPU_W-1:0] lane_idx;
  logic              wr_sh;

  always_comb begin
    if (word_idx < WIDX_W'(PRIV / 4))  kind = WK_PRIV;
    else if (word_idx < WIDX_W'(NWORD)) kind = WK_SHARED;
    else                                kind = WK_NONE;
    base_irq = {word_idx, 2'b00};
    base_sh  = base_irq - BA_W'(PRIV);
    wr_sh    = wr_en && (kind == WK_SHARED);
  end

  // One storage slot per shared interrupt.
  for (genvar s = 0; s < NSH; s++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_sh && (word_idx == WIDX_W'((s + PRIV) / 4));
    tgt_slot #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_slot (
      .clk  (clk),
      .rst  (rst),
      .we   (slot_we),
      .wbyte(wr_data[8*(s%4) +: 8]),
      .idx  (cur_idx[s]),
      .map  (route_map[s*NUM_CPU +: NUM_CPU])
    );
  end

  // Gather the four lanes of the addressed word for the read path.
  for (genvar j = 0; j < 4; j++) begin : g_lane
    logic [SL_W-1:0] sl;
    assign sl = SL_W'(base_sh) + SL_W'(j);
    assign lane_idx[CPU_W*j +: CPU_W] = (kind == WK_SHARED) ? cur_idx[sl] : '0;
  end

  tgt_rd #(.CPU_W(CPU_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .kind    (kind),
    .acc_cpu (acc_cpu),
    .lane_idx(lane_idx),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) upd <= 1'b0;
    else     upd <= wr_sh;
  end
endmodule

// File: rtl/tgt_bank_chk.sv
module tgt_bank_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  localparam int PRIV   = 32,
  localparam int NSH    = NUM_IRQ - PRIV,
  localparam int NWORD  = NUM_IRQ / 4,
  localparam int WIDX_W = $clog2(NWORD) + 1,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [WIDX_W-1:0]      word_idx,
  input logic [31:0]            wr_data,
  input logic [CPU_W-1:0]       acc_cpu,
  input logic [31:0]            rd_data,
  input logic                   rd_valid,
  input logic                   upd,
  input logic [NSH*NUM_CPU-1:0] route_map
);
  logic sh_wr, priv_rd, none_rd;
  assign sh_wr   = wr_en && (word_idx >= WIDX_W'(PRIV / 4)) && (word_idx < WIDX_W'(NWORD));
  assign priv_rd = rd_en && (word_idx < WIDX_W'(PRIV / 4));
  assign none_rd = rd_en && (word_idx >= WIDX_W'(NWORD));

  for (genvar s = 0; s < NSH; s++) begin : g_oh
    AST_MAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(route_map[s*NUM_CPU +: NUM_CPU]) == 1); // R5
  end

  AST_UPD_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    sh_wr |=> upd); // R7
  AST_NO_UPD: assert property (@(posedge clk) disable iff (rst)
    !sh_wr |=> !upd); // R7
  AST_MAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sh_wr |=> $stable(route_map)); // R7
  AST_PRIV_READ: assert property (@(posedge clk) disable iff (rst)
    priv_rd |=> rd_data == {4{8'(8'd1 << $past(acc_cpu))}}); // R4
  AST_NONE_READ: assert property (@(posedge clk) disable iff (rst)
    none_rd |=> rd_data == 32'd0); // R8
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R9
endmodule

bind tgt_bank tgt_bank_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .word_idx (word_idx),
  .wr_data  (wr_data),
  .acc_cpu  (acc_cpu),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .upd      (upd),
  .route_map(route_map)
);

// File: tb/sim_tgt_bank.sv
module sim_tgt_bank;
  localparam int NUM_IRQ = 64;
  localparam int NUM_CPU = 8;
  localparam int NSH     = NUM_IRQ - 32;
  localparam int WIDX_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDX_W-1:0] word_idx = '0;
  logic [31:0]       wr_data = '0;
  logic [2:0]        acc_cpu = '0;
  logic [31:0]       rd_data;
  logic              rd_valid, upd;
  logic [NSH*NUM_CPU-1:0] route_map;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int exp_tgt [NSH];

  always #2 clk = ~clk;

  tgt_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .word_idx(word_idx),
    .wr_data(wr_data), .acc_cpu(acc_cpu), .rd_data(rd_data), .rd_valid(rd_valid),
    .upd(upd), .route_map(route_map)
  );

  function automatic int pick_cpu(input logic [7:0] b);
    for (int i = 0; i < 8; i++) if (b[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_word(input int w, input int cpu);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      if (w < 8)                r[8*j +: 8] = 8'(1 << cpu);
      else if (w < NUM_IRQ / 4) r[8*j +: 8] = 8'(1 << exp_tgt[4*w + j - 32]);
    end
    return r;
  endfunction

  function automatic logic [NSH*NUM_CPU-1:0] exp_map();
    logic [NSH*NUM_CPU-1:0] m = '0;
    for (int s = 0; s < NSH; s++) m[s*NUM_CPU + exp_tgt[s]] = 1'b1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_map(input string req);
    logic [NSH*NUM_CPU-1:0] e = exp_map();
    total++;
    if (route_map !== e) begin
      bad++;
      $display("FAIL %s route_map act=%h exp=%h", req, route_map, e);
    end
  endtask

  task automatic do_write(input int w, input logic [31:0] d, input string req);
    bit shared = (w >= 8) && (w < NUM_IRQ / 4);
    @(negedge clk);
    wr_en = 1'b1; word_idx = WIDX_W'(w); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (shared)
      for (int j = 0; j < 4; j++) exp_tgt[4*w + j - 32] = pick_cpu(d[8*j +: 8]);
    chk(upd === shared, {req, " upd after write"}, 32'(upd), 32'(shared));
    chk_map(req);
    @(negedge clk);
    chk(upd === 1'b0, "R7 upd one cycle", 32'(upd), 32'd0);
  endtask

  task automatic do_read(input int w, input int cpu, input string req);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; word_idx = WIDX_W'(w); acc_cpu = 3'(cpu);
    @(negedge clk);
    rd_en = 1'b0;
    e = exp_word(w, cpu);
    chk(rd_valid === 1'b1, "R9 rd_valid", 32'(rd_valid), 32'd1);
    chk(rd_data === e, req, rd_data, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int s = 0; s < NSH; s++) exp_tgt[s] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk(rd_valid === 1'b0 && upd === 1'b0, "R6 idle after reset", {30'd0, rd_valid, upd}, 32'd0);
    chk_map("R6 reset map");
    do_read(8, 0, "R6 reset readback");
    do_read(15, 3, "R6 reset readback last word");
    // R2/R3/R1: mixed bytes, lanes laid out per ID
    do_write(8, 32'h800C_0003, "R2 directed write");
    do_read(8, 0, "R1 R2 R3 directed readback");
    do_write(9, 32'hFF00_0200, "R3 zero byte");
    do_read(9, 1, "R3 zero byte readback");
    // R4: private words ignore writes, read accessing CPU
    do_write(2, 32'hFFFF_FFFF, "R4 private write ignored");
    do_read(2, 5, "R4 private read cpu5");
    do_read(7, 0, "R4 private read cpu0");
    do_read(0, 7, "R4 private read cpu7");
    // R8: beyond range
    do_write(16, 32'h0404_0404, "R8 oor write ignored");
    do_write(31, 32'h8080_8080, "R8 oor write ignored top");
    do_read(20, 2, "R8 oor read zero");
    do_read(8, 0, "R8 shared unchanged after oor write");
    // R9: rd_valid low when idle
    @(negedge clk);
    chk(rd_valid === 1'b0, "R9 rd_valid idle", 32'(rd_valid), 32'd0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      int w = int'($urandom_range(31, 0));
      if ($urandom_range(1, 0) == 1) begin
        logic [31:0] d;
        for (int j = 0; j < 4; j++)
          d[8*j +: 8] = ($urandom_range(3, 0) == 0) ? 8'd0 : 8'($urandom);
        do_write(w, d, "R2 R5 random write");
      end else begin
        do_read(w, int'($urandom_range(7, 0)), "R1 R2 R4 R8 random read");
      end
    end
    for (int w = 8; w < 16; w++) do_read(w, 0, "R2 final sweep");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule